// File: doc/BRIEF.md
# Multichannel DMA Halt/Resume Controller

This block moves single words for several DMA channels over a simple memory bus. Each channel holds a source address, a destination address, a remaining-transfer count, an enable bit, an end flag and a retained-request flag. An external request pulse on a channel is latched; when the channel is enabled and its count is non-zero, a round-robin arbiter selects it. The block presents the source and destination addresses on the bus and holds them until the bus acknowledges. The acknowledge advances both addresses by one word, lowers the count by one, and sends a one-cycle acknowledge back to the requesting channel.

Two global controls stop all channels without losing progress. One is a master-enable bit written by software. The other is an NMI flag set by a rising edge on a pin. A halt only prevents new bus cycles from starting, so a cycle already in progress completes. After the halt, each channel's registers show the next address and the transfers still outstanding, and no end flag is raised. While the NMI flag is set, new requests are refused. Software clears the flag by reading it as 1 and then writing 0.

Top module: `dma_halt_ctrl`

## Requirements
- R1: After reset every register reads 0 (master enable off, NMI flag clear, all channel fields zero), and bus_valid is 0.
- R2: A granted transfer shows the channel's source and destination on bus_src/bus_dst. On bus_ack, both addresses rise by WORD_BYTES, the count falls by 1, and ch_ack pulses for that channel in the same cycle.
- R3: When a normal transfer brings the count to 0, the channel's end flag (control bit 1) is set, and the channel starts no further transfers even if a request is pending.
- R4: Requesting channels are granted round-robin, starting with the channel after the one granted last.
- R5: While master enable (global bit 0) is 0, no transfer starts. The channel registers keep the next address and remaining count, and no end flag is set. Writing 1 resumes with the next pending transfer.
- R6: A halt does not cut short a bus cycle already presented. bus_valid and the addresses hold until bus_ack, and the channel update is still applied.
- R7: A rising edge on nmi_in sets the NMI flag (global bit 1) one cycle later. It stops all new transfers without setting any end flag and without changing addresses or counts.
- R8: While the NMI flag is 1, an ext_req pulse is not accepted, and the retained-request bit stays 0.
- R9: The NMI flag clears only on a global-register write with bit 1 = 0 that follows a read of the global register while the flag was 1. A write of 0 without that read is ignored.
- R10: An nmi_in rising edge in the same cycle as a clearing write leaves the NMI flag at 1.
- R11: Control bit 2 reads 1 once a request has been accepted and not yet serviced. Writing 1 to it clears it, but a request arriving in the same cycle keeps it at 1.
- R12: A channel whose enable bit (control bit 0) is 0 starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on NMI clear sequence) |
| reg_addr | input | RA_W | Register address: top bit selects global, then channel index, then field (0 src, 1 dst, 2 count, 3 control) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| nmi_in | input | 1 | NMI input; rising edge sets the NMI flag |
| ext_req | input | NCH | Per-channel request pulses |
| ch_ack | output | NCH | Per-channel acknowledge, one cycle, on transfer completion |
| bus_valid | output | 1 | Bus transfer presented |
| bus_src | output | AW | Source word address of presented transfer |
| bus_dst | output | AW | Destination word address of presented transfer |
| bus_ack | input | 1 | Bus completes presented transfer |

## Verification
The hardest conditions to reach from the ports are a halt arriving while a bus cycle is outstanding, and a clearing write landing in the same cycle as a new NMI edge. The stimulus for the first holds bus_ack low, waits for bus_valid, and then clears master enable before acknowledging. The stimulus for the second lowers nmi_in, arms the clear by reading the flag, and then raises nmi_in in the very cycle of the write. Retained-request priority is reached the same way, by putting a write-one-to-clear and a request pulse on one clock edge, on a channel whose count is already 0 so that nothing services the request.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {
        FLD_SRC = 2'd0,
        FLD_DST = 2'd1,
        FLD_CNT = 2'd2,
        FLD_CTL = 2'd3
    } fld_e;

    localparam int CTL_EN  = 0;
    localparam int CTL_END = 1;
    localparam int CTL_RET = 2;
    localparam int GL_ME   = 0;
    localparam int GL_NMI  = 1;
endpackage

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] gidx,
    output logic          any
);
    logic [IW-1:0] ptr_q, ptr_d;

    always_comb begin
        grant = '0;
        gidx  = '0;
        any   = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % N;
            if (!any && req[idx]) begin
                any        = 1'b1;
                grant[idx] = 1'b1;
                gidx       = IW'(idx);
            end
        end
        ptr_d = (adv && any) ? gidx : ptr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= IW'(N - 1);
        else        ptr_q <= ptr_d;
    end

    // R4: a grant always goes to one requester, and only when one asks
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));
    // R4: the channel just served loses the next contest against an unchanged request set
    p_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && $countones(req) > 1) |=> !(adv && req == $past(req) && grant == $past(grant)));
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_fld,
    input  logic [31:0]   wdata,
    input  logic          ext_req,
    input  logic          accept,
    input  logic          done,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output logic          en,
    output logic          endf,
    output logic          ret,
    output logic          ready
);
    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic          en;
        logic          endf;
        logic          ret;
    } ch_t;

    ch_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (fld_e'(wr_fld))
                FLD_SRC: s_d.src = wdata[AW-1:0];
                FLD_DST: s_d.dst = wdata[AW-1:0];
                FLD_CNT: begin
                    s_d.cnt  = wdata[CW-1:0];
                    s_d.endf = 1'b0;
                end
                default: begin
                    s_d.en = wdata[CTL_EN];
                    if (wdata[CTL_RET]) s_d.ret = 1'b0;
                end
            endcase
        end
        if (done) begin
            s_d.src = s_q.src + AW'(WORD_BYTES);
            s_d.dst = s_q.dst + AW'(WORD_BYTES);
            s_d.cnt = s_q.cnt - CW'(1);
            s_d.ret = 1'b0;
            if (s_q.cnt == CW'(1)) s_d.endf = 1'b1;
        end
        if (ext_req && accept) s_d.ret = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign src   = s_q.src;
    assign dst   = s_q.dst;
    assign cnt   = s_q.cnt;
    assign en    = s_q.en;
    assign endf  = s_q.endf;
    assign ret   = s_q.ret;
    assign ready = s_q.en && s_q.ret && (s_q.cnt != '0);

    // R3: the end flag only rises on a completed transfer, never on a halt
    p_end_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(endf) |-> $past(done));
    // R2: each completion lowers the count by one
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(wr_en && wr_fld == 2'd2)) |=> cnt == $past(cnt) - CW'(1));
    // R11: an accepted request is always recorded
    p_ret_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && accept) |=> ret);
    // R8: a refused request leaves the flag clear
    p_ret_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !ret) |=> !ret);
endmodule

// File: rtl/dma_halt_ctrl.sv
module dma_halt_ctrl
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int WORD_BYTES = 4,
    localparam int CIW  = $clog2(NCH),
    localparam int RA_W = CIW + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            nmi_in,
    input  logic [NCH-1:0]  ext_req,
    output logic [NCH-1:0]  ch_ack,
    output logic            bus_valid,
    output logic [AW-1:0]   bus_src,
    output logic [AW-1:0]   bus_dst,
    input  logic            bus_ack
);
    typedef struct packed {
        logic           me;
        logic           nmi;
        logic           armed;
        logic           nmi_in_q;
        logic           busy;
        logic [CIW-1:0] cur;
    } top_t;

    top_t t_q, t_d;

    logic [AW-1:0]  src_a [NCH];
    logic [AW-1:0]  dst_a [NCH];
    logic [CW-1:0]  cnt_a [NCH];
    logic [NCH-1:0] en_v, end_v, ret_v, rdy_v, arb_req, grant;
    logic [CIW-1:0] gidx, chi;
    logic           any, glob_sel, nmi_edge, xfer_done;

    assign glob_sel  = reg_addr[RA_W-1];
    assign chi       = reg_addr[RA_W-2:2];
    assign nmi_edge  = nmi_in && !t_q.nmi_in_q;
    assign xfer_done = t_q.busy && bus_ack;
    assign arb_req   = rdy_v & {NCH{t_q.me && !t_q.nmi}};

    dma_rr_arb #(.N(NCH)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(arb_req), .adv(!t_q.busy),
        .grant(grant), .gidx(gidx), .any(any)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic wr_c, done_c;
        assign wr_c   = reg_wr && !glob_sel && (chi == CIW'(c));
        assign done_c = xfer_done && (t_q.cur == CIW'(c));
        assign ch_ack[c] = done_c;
        dma_chan #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_ch (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_c), .wr_fld(reg_addr[1:0]),
            .wdata(reg_wdata), .ext_req(ext_req[c]), .accept(!t_q.nmi),
            .done(done_c), .src(src_a[c]), .dst(dst_a[c]), .cnt(cnt_a[c]),
            .en(en_v[c]), .endf(end_v[c]), .ret(ret_v[c]), .ready(rdy_v[c])
        );
    end

    always_comb begin
        t_d = t_q;
        t_d.nmi_in_q = nmi_in;
        if (reg_rd && glob_sel && t_q.nmi) t_d.armed = 1'b1;
        if (reg_wr && glob_sel) begin
            t_d.me    = reg_wdata[GL_ME];
            t_d.armed = 1'b0;
            if (t_q.armed && !reg_wdata[GL_NMI]) t_d.nmi = 1'b0;
        end
        if (nmi_edge) t_d.nmi = 1'b1;
        if (xfer_done) begin
            t_d.busy = 1'b0;
        end else if (!t_q.busy && any) begin
            t_d.busy = 1'b1;
            t_d.cur  = gidx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (glob_sel) begin
            reg_rdata[GL_ME]  = t_q.me;
            reg_rdata[GL_NMI] = t_q.nmi;
        end else if (int'(chi) < NCH) begin
            case (fld_e'(reg_addr[1:0]))
                FLD_SRC: reg_rdata = 32'(src_a[chi]);
                FLD_DST: reg_rdata = 32'(dst_a[chi]);
                FLD_CNT: reg_rdata = 32'(cnt_a[chi]);
                default: begin
                    reg_rdata[CTL_EN]  = en_v[chi];
                    reg_rdata[CTL_END] = end_v[chi];
                    reg_rdata[CTL_RET] = ret_v[chi];
                end
            endcase
        end
    end

    assign bus_valid = t_q.busy;
    assign bus_src   = src_a[t_q.cur];
    assign bus_dst   = dst_a[t_q.cur];

    // R6: a presented bus cycle holds until acknowledged
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ack) |=> bus_valid && $stable(bus_src) && $stable(bus_dst));
    // R5 / R7: a new bus cycle starts only when running
    p_launch_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> $past(t_q.me && !t_q.nmi));
    // R10: an nmi edge always lands in the flag
    p_nmi_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_in && !t_q.nmi_in_q) |=> t_q.nmi);
    // R9: the flag falls only on an armed zero write
    p_nmi_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(t_q.nmi) |-> $past(reg_wr && glob_sel && !reg_wdata[GL_NMI] && t_q.armed));
endmodule

// File: tb/dma_halt_ctrl_tb.sv
module dma_halt_ctrl_tb;
    localparam int NCH = 4;
    localparam int AW = 32;
    localparam int RA_W = 5;
    localparam logic [RA_W-1:0] GLB = 5'd16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0, reg_rd = 1'b0;
    logic [RA_W-1:0] reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            nmi_in = 1'b0;
    logic [NCH-1:0]  ext_req = '0;
    logic [NCH-1:0]  ch_ack;
    logic            bus_valid;
    logic [AW-1:0]   bus_src, bus_dst;
    logic            bus_ack = 1'b0;

    int total = 0;
    int bad = 0;
    bit fin = 1'b0;

    always #10 clk = ~clk;

    dma_halt_ctrl #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nmi_in(nmi_in), .ext_req(ext_req), .ch_ack(ch_ack),
        .bus_valid(bus_valid), .bus_src(bus_src), .bus_dst(bus_dst), .bus_ack(bus_ack)
    );

    // op(1: 1=read-check, 0=write) | addr(5) | data(32)
    localparam logic [37:0] VEC [14] = '{
        {1'b1, 5'd16, 32'h0}, {1'b1, 5'd3, 32'h0},
        {1'b0, 5'd0, 32'h1000}, {1'b0, 5'd1, 32'h2000}, {1'b0, 5'd2, 32'd4},
        {1'b0, 5'd4, 32'h3000}, {1'b0, 5'd5, 32'h4000}, {1'b0, 5'd6, 32'd2},
        {1'b1, 5'd0, 32'h1000}, {1'b1, 5'd1, 32'h2000}, {1'b1, 5'd2, 32'd4},
        {1'b1, 5'd4, 32'h3000}, {1'b1, 5'd5, 32'h4000}, {1'b1, 5'd6, 32'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [RA_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [RA_W-1:0] a, input logic [31:0] e);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 chk(tag, reg_rdata, e);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic req(input logic [NCH-1:0] m);
        @(negedge clk);
        ext_req = m;
        @(posedge clk); #1;
        ext_req = '0;
    endtask

    task automatic idle_chk(input string tag, input int n);
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bus_valid) seen = 1'b1;
        end
        chk(tag, {31'b0, seen}, 32'h0);
    endtask

    task automatic serve(input string tag, input logic [31:0] s, input logic [31:0] d, input int ch);
        int w;
        w = 0;
        @(negedge clk);
        while (!bus_valid && w < 30) begin
            @(negedge clk);
            w++;
        end
        chk({tag, " valid"}, {31'b0, bus_valid}, 32'h1);
        chk({tag, " src"}, bus_src, s);
        chk({tag, " dst"}, bus_dst, d);
        bus_ack = 1'b1;
        #1 chk({tag, " ack"}, 32'(ch_ack), 32'(1 << ch));
        @(posedge clk); #1;
        bus_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bus_valid after reset", {31'b0, bus_valid}, 32'h0);

        // R1 / R2: configuration and readback table
        for (int i = 0; i < 14; i++) begin
            if (VEC[i][37]) rd("R1/R2 table read", VEC[i][36:32], VEC[i][31:0]);
            else            wr(VEC[i][36:32], VEC[i][31:0]);
        end

        // R12: disabled channel does not move; R11: request retained
        wr(GLB, 32'h1);
        req(4'b0001);
        idle_chk("R12 disabled channel idle", 5);
        rd("R11 retained set", 5'd3, 32'h4);

        // R2: single transfer and address/count update
        wr(5'd3, 32'h1);
        serve("R2 ch0 first", 32'h1000, 32'h2000, 0);
        rd("R2 src step", 5'd0, 32'h1004);
        rd("R2 dst step", 5'd1, 32'h2004);
        rd("R2 cnt step", 5'd2, 32'd3);
        rd("R2 ctrl after", 5'd3, 32'h1);

        // R4: round robin after ch0 was last served
        wr(5'd7, 32'h1);
        req(4'b0011);
        serve("R4 ch1 first", 32'h3000, 32'h4000, 1);
        serve("R4 ch0 second", 32'h1004, 32'h2004, 0);

        // R6: halt while a cycle is outstanding
        req(4'b0001);
        @(negedge clk);
        while (!bus_valid) @(negedge clk);
        wr(GLB, 32'h0);
        @(negedge clk);
        chk("R6 valid held over halt", {31'b0, bus_valid}, 32'h1);
        serve("R6 in-flight completes", 32'h1008, 32'h2008, 0);
        rd("R6 cnt after", 5'd2, 32'd1);

        // R5: master enable clear blocks, keeps state, no end flag
        req(4'b0001);
        idle_chk("R5 halted idle", 5);
        rd("R5 ctrl retained no end", 5'd3, 32'h5);
        rd("R5 src kept", 5'd0, 32'h100C);
        rd("R5 cnt kept", 5'd2, 32'd1);
        wr(GLB, 32'h1);
        serve("R5 resume", 32'h100C, 32'h200C, 0);

        // R3: end flag and stop at zero
        rd("R3 end flag", 5'd3, 32'h3);
        rd("R3 cnt zero", 5'd2, 32'd0);
        req(4'b0001);
        idle_chk("R3 no transfer at zero", 4);
        rd("R3 retained while stopped", 5'd3, 32'h7);

        // R11: clear races with new request
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd3; reg_wdata = 32'h5; ext_req = 4'b0001;
        @(posedge clk); #1;
        reg_wr = 1'b0; ext_req = '0;
        rd("R11 request beats clear", 5'd3, 32'h7);
        wr(5'd3, 32'h5);
        rd("R11 write-one clears", 5'd3, 32'h3);

        // R7 / R8: NMI halt
        @(negedge clk); nmi_in = 1'b1;
        repeat (2) @(negedge clk);
        req(4'b0010);
        idle_chk("R7 nmi halts", 4);
        rd("R8 request refused, R7 no end", 5'd7, 32'h1);
        rd("R7 cnt kept", 5'd6, 32'd1);
        rd("R7 src kept", 5'd4, 32'h3004);
        @(negedge clk); nmi_in = 1'b0;
        repeat (2) @(negedge clk);

        // R9: zero write without prior read ignored
        wr(GLB, 32'h1);
        rd("R9 unarmed write ignored", GLB, 32'h3);

        // R10: new edge beats armed clear
        @(negedge clk);
        nmi_in = 1'b1; reg_wr = 1'b1; reg_addr = GLB; reg_wdata = 32'h1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        rd("R10 edge beats clear", GLB, 32'h3);

        // R9: armed clear succeeds
        wr(GLB, 32'h1);
        rd("R9 armed clear", GLB, 32'h1);
        @(negedge clk); nmi_in = 1'b0;

        req(4'b0010);
        serve("R8 fresh request after resume", 32'h3004, 32'h4004, 1);
        rd("R3 ch1 end", 5'd7, 32'h3);

        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule